// File: doc/BRIEF.md
# SPI Master Shift-Clock Generator

This block produces the serial clock and the per-edge timing strobes for the master side of a synchronous serial port. A free-running system clock is divided down to one of seven power-of-two bit rates. Every time the transmit shift register has been written, the divider is cleared and a new frame of eight data bits is timed. The clock phase and polarity settings decide which edge samples and which edge shifts, and the level the serial clock rests at. The data path, slave operation and the register interface are outside this block.

The divider restarts from the end of each register write. When the clock phase is zero, the first serial clock transition is held back by half a bit period, so the first data bit gets setup time and the same length as the other bits. When the clock phase is one, the first transition follows the write at once, because that edge shifts out the first bit. All outputs are registered. Each one-cycle strobe is high in the same cycle in which the serial clock shows the edge it marks.

Top module: `spi_brg_master`

## Requirements
- R1: After reset, `sclk`, `busy` and all four edge strobes are low.
- R2: While no frame is running, `sclk` equals the `cpol` value sampled on the previous clock edge.
- R3: The half bit period H is 2^(rate_sel+2) clock cycles for `rate_sel` 0 to 6 (bit rate = clock/8 to clock/512). `rate_sel` 7 gives the same H as 6.
- R4: With `cpha`=0, the first `sclk` transition happens H clock edges after the edge that samples `load_stb`. Each later transition follows the one before it by H edges.
- R5: With `cpha`=1, the first `sclk` transition happens on the edge right after the one that samples `load_stb`. Later transitions are H edges apart.
- R6: A frame has exactly 16 transitions. `busy` rises on the edge that samples the strobe and falls on the edge of the 16th transition, and `sclk` is then back at `cpol`.
- R7: `lead_en` is high for one cycle with the 1st, 3rd, ... 15th transition. `trail_en` is high for one cycle with the 2nd, 4th, ... 16th transition. Each strobe is high in the cycle where `sclk` first shows the new level, and the two are never high together.
- R8: With `cpha`=0, `sample_en` equals `lead_en` and `shift_en` equals `trail_en`. With `cpha`=1 the two are swapped.
- R9: A `load_stb` while a frame is running restarts the frame from that strobe, with the rate and phase present at that strobe.
- R10: `rate_sel` and `cpha` are captured with `load_stb`. Changing them during a frame has no effect on its timing.
- R11: While `mst_en` is low, `load_stb` is ignored and no frame runs. Dropping `mst_en` during a frame ends it: on the next edge `busy` is low and `sclk` equals `cpol`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mst_en | input | 1 | Master operation enable |
| rate_sel | input | 3 | Bit-rate select, 0 = clock/8 ... 6 = clock/512, 7 = clock/512 |
| cpha | input | 1 | Clock phase: 0 = sample on leading edge, 1 = shift on leading edge |
| cpol | input | 1 | Idle level of the serial clock |
| load_stb | input | 1 | One-cycle pulse at the end of a shift-register write |
| sclk | output | 1 | Serial clock |
| busy | output | 1 | High while a frame is being timed |
| lead_en | output | 1 | Strobe with each leading serial clock edge |
| trail_en | output | 1 | Strobe with each trailing serial clock edge |
| shift_en | output | 1 | Strobe on the edges that shift out data |
| sample_en | output | 1 | Strobe on the edges that sample input data |

## Verification
Whole frames are traced cycle by cycle at the fastest rate, at an intermediate rate, at the slowest encoded rate and at the alias encoding 7. The fast and slow cases show whether the half-period arithmetic scales. Select 7 against select 6 shows whether the alias is handled. Both phases are run with both polarities: the position of the first transition separates the half-period hold-back from the immediate start, and the swap of the sample and shift strobes shows that the phase is applied. Extra runs change the rate and phase inputs during a frame, reload during a frame, drop the enable during a frame, pulse the strobe while disabled, and toggle the polarity at idle. These separate captured settings from live inputs, and a restart from an ignored strobe.

// File: rtl/spibrg_pkg.sv
package spibrg_pkg;

  // log2 of the half bit period in clock cycles for a given select code.
  // Codes at or beyond the number of rates fall back to the slowest rate.
  function automatic int half_log2(input int sel, input int min_div_log2, input int rates);
    int s;
    s = (sel >= rates) ? rates - 1 : sel;
    return min_div_log2 - 1 + s;
  endfunction

  // Number of serial clock transitions in one frame.
  function automatic int frame_edges(input int data_bits);
    return 2 * data_bits;
  endfunction

endpackage

// File: rtl/brg_rate_latch.sv
module brg_rate_latch #(
  parameter int SEL_W        = 3,
  parameter int CW           = 8,
  parameter int MIN_DIV_LOG2 = 3,
  parameter int RATE_COUNT   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             cpha,
  output logic [CW-1:0]    start_val,
  output logic [CW-1:0]    half_m1_q,
  output logic             cpha_q
);
  import spibrg_pkg::*;

  logic [CW-1:0] half_m1_now;

  always_comb begin
    half_m1_now = CW'((32'd1 << half_log2(int'(rate_sel), MIN_DIV_LOG2, RATE_COUNT)) - 32'd1);
    // Phase 0 waits a full half period before the first edge; phase 1 fires next cycle.
    start_val   = cpha ? '0 : half_m1_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_m1_q <= '0;
      cpha_q    <= 1'b0;
    end else if (capture) begin
      half_m1_q <= half_m1_now;
      cpha_q    <= cpha;
    end
  end

endmodule

// File: rtl/brg_half_timer.sv
module brg_half_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] start_val,
  input  logic          run,
  input  logic [CW-1:0] reload_val,
  output logic          tick
);

  logic [CW-1:0] cnt;

  assign tick = run && !restart && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= start_val;
    end else if (run) begin
      if (cnt == '0) cnt <= reload_val;
      else           cnt <= cnt - 1'b1;
    end else begin
      cnt <= '0;
    end
  end

endmodule

// File: rtl/brg_edge_seq.sv
module brg_edge_seq #(
  parameter int EDGES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start,
  input  logic tick,
  input  logic cpha_q,
  input  logic cpol,
  output logic active,
  output logic last_edge,
  output logic sclk,
  output logic lead_en,
  output logic trail_en,
  output logic shift_en,
  output logic sample_en
);

  localparam int EW = (EDGES > 2) ? $clog2(EDGES) : 1;

  logic [EW-1:0] eidx;
  logic          leading;

  assign leading   = ~eidx[0];
  assign last_edge = active && tick && (eidx == EW'(EDGES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      eidx      <= '0;
      sclk      <= 1'b0;
      lead_en   <= 1'b0;
      trail_en  <= 1'b0;
      shift_en  <= 1'b0;
      sample_en <= 1'b0;
    end else begin
      lead_en   <= 1'b0;
      trail_en  <= 1'b0;
      shift_en  <= 1'b0;
      sample_en <= 1'b0;
      if (!enable) begin
        active <= 1'b0;
        eidx   <= '0;
        sclk   <= cpol;
      end else if (start) begin
        active <= 1'b1;
        eidx   <= '0;
        sclk   <= cpol;
      end else if (active && tick) begin
        sclk      <= ~sclk;
        lead_en   <= leading;
        trail_en  <= ~leading;
        sample_en <= cpha_q ? ~leading : leading;
        shift_en  <= cpha_q ? leading : ~leading;
        eidx      <= eidx + 1'b1;
        if (last_edge) active <= 1'b0;
      end else if (!active) begin
        sclk <= cpol;
      end
    end
  end

endmodule

// File: rtl/spi_brg_master.sv
module spi_brg_master #(
  parameter int DATA_BITS    = 8,
  parameter int MIN_DIV_LOG2 = 3,
  parameter int RATE_COUNT   = 7,
  parameter int SEL_W        = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mst_en,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             cpha,
  input  logic             cpol,
  input  logic             load_stb,
  output logic             sclk,
  output logic             busy,
  output logic             lead_en,
  output logic             trail_en,
  output logic             shift_en,
  output logic             sample_en
);
  import spibrg_pkg::*;

  localparam int MAX_LOG2 = MIN_DIV_LOG2 - 1 + RATE_COUNT - 1;
  localparam int CW       = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;
  localparam int EDGES    = frame_edges(DATA_BITS);

  // Named internal events, observed by the bound checker.
  logic          start_evt;
  logic          edge_tick;
  logic          last_edge;
  logic          cpha_q;
  logic [CW-1:0] half_m1_q;
  logic [CW-1:0] start_val;

  assign start_evt = load_stb && mst_en;

  brg_rate_latch #(
    .SEL_W(SEL_W), .CW(CW), .MIN_DIV_LOG2(MIN_DIV_LOG2), .RATE_COUNT(RATE_COUNT)
  ) u_rate (
    .clk(clk), .rst_n(rst_n), .capture(start_evt), .rate_sel(rate_sel), .cpha(cpha),
    .start_val(start_val), .half_m1_q(half_m1_q), .cpha_q(cpha_q)
  );

  brg_half_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(start_evt), .start_val(start_val),
    .run(busy), .reload_val(half_m1_q), .tick(edge_tick)
  );

  brg_edge_seq #(.EDGES(EDGES)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(mst_en), .start(start_evt), .tick(edge_tick),
    .cpha_q(cpha_q), .cpol(cpol), .active(busy), .last_edge(last_edge), .sclk(sclk),
    .lead_en(lead_en), .trail_en(trail_en), .shift_en(shift_en), .sample_en(sample_en)
  );

endmodule

// File: rtl/brg_checks.sv
module brg_checks #(
  parameter int HW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mst_en,
  input logic          cpol,
  input logic          start_evt,
  input logic          edge_tick,
  input logic          last_edge,
  input logic          cpha_q,
  input logic [HW-1:0] half_m1_q,
  input logic          sclk,
  input logic          busy,
  input logic          lead_en,
  input logic          trail_en,
  input logic          shift_en,
  input logic          sample_en
);

  logic past_valid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_valid <= 1'b0;
    else        past_valid <= 1'b1;
  end

  // R2: idle serial clock follows polarity
  a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && !$past(busy)) |-> (sclk == $past(cpol)));

  // R6: frame ends right after the last edge, on a trailing strobe
  a_r6_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (last_edge && mst_en) |=> (!busy && trail_en && sclk == $past(cpol)));

  a_r6_fall_reason: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(mst_en)) |-> $past(last_edge));

  // R7: strobes exclusive and coincident with a level change
  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lead_en, trail_en}));

  a_r7_strobe_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_en || trail_en) |-> (sclk != $past(sclk)));

  a_r7_tick_gives_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_tick && mst_en) |=> (lead_en || trail_en));

  // R8: phase selects which strobe samples
  a_r8_sample_map: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_en || trail_en) |-> (sample_en == (cpha_q ? trail_en : lead_en)
                               && shift_en == (cpha_q ? lead_en : trail_en)));

  // R10: captured settings hold for the frame
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(start_evt)) |-> ($stable(half_m1_q) && $stable(cpha_q)));

  // R11: disabled means idle next cycle
  a_r11_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !mst_en |=> !busy);

endmodule

bind spi_brg_master brg_checks u_chk (
  .clk(clk), .rst_n(rst_n), .mst_en(mst_en), .cpol(cpol), .start_evt(start_evt),
  .edge_tick(edge_tick), .last_edge(last_edge), .cpha_q(cpha_q), .half_m1_q(half_m1_q),
  .sclk(sclk), .busy(busy), .lead_en(lead_en), .trail_en(trail_en),
  .shift_en(shift_en), .sample_en(sample_en)
);

// File: tb/sim_spi_brg_master.sv
module sim_spi_brg_master;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mst_en = 1'b0;
  logic [2:0] rate_sel = '0;
  logic cpha = 1'b0;
  logic cpol = 1'b0;
  logic load_stb = 1'b0;
  logic sclk, busy, lead_en, trail_en, shift_en, sample_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  spi_brg_master u0 (
    .clk(clk), .rst_n(rst_n), .mst_en(mst_en), .rate_sel(rate_sel), .cpha(cpha),
    .cpol(cpol), .load_stb(load_stb), .sclk(sclk), .busy(busy), .lead_en(lead_en),
    .trail_en(trail_en), .shift_en(shift_en), .sample_en(sample_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Full frame trace; expected timing computed from the requirements.
  task automatic xfer(input int sel, input bit ph, input bit pol, input bit perturb,
                      input string tag);
    int h, first, last_t, bad_sclk, bad_pulse, bad_map, obs_first, obs_fall, nlead, ntrail;
    h = 1 << (2 + ((sel > 6) ? 6 : sel));
    first = ph ? 1 : h;
    last_t = first + 15 * h;
    bad_sclk = 0; bad_pulse = 0; bad_map = 0; obs_first = -1; obs_fall = -1;
    nlead = 0; ntrail = 0;
    @(negedge clk);
    rate_sel = sel[2:0]; cpha = ph; cpol = pol; load_stb = 1'b1;
    @(negedge clk);
    load_stb = 1'b0;
    for (int n = 0; n <= last_t + 2; n++) begin
      int tog, k;
      bit e_lead, e_trail;
      tog = (n < first) ? 0 : ((n - first) / h + 1);
      if (tog > 16) tog = 16;
      k = -1;
      if (n >= first && ((n - first) % h) == 0 && ((n - first) / h) < 16) k = (n - first) / h;
      e_lead = (k >= 0) && (k % 2 == 0);
      e_trail = (k >= 0) && (k % 2 == 1);
      if (sclk != (pol ^ tog[0])) bad_sclk++;
      if (lead_en != e_lead || trail_en != e_trail) bad_pulse++;
      if (sample_en != (ph ? e_trail : e_lead) || shift_en != (ph ? e_lead : e_trail)) bad_map++;
      if (obs_first < 0 && sclk != pol) obs_first = n;
      if (obs_fall < 0 && !busy) obs_fall = n;
      if (lead_en) nlead++;
      if (trail_en) ntrail++;
      if (perturb && n == 3) begin
        rate_sel = (sel == 0) ? 3'd5 : 3'd0;
        cpha = ~ph;
      end
      @(negedge clk);
    end
    check(obs_first == first, {tag, " R4/R5 first transition"}, obs_first, first);
    check(bad_sclk == 0, {tag, " R3 sclk trace mismatches"}, bad_sclk, 0);
    check(obs_fall == last_t, {tag, " R6 busy fall cycle"}, obs_fall, last_t);
    check(sclk == pol, {tag, " R6 end level"}, sclk, pol);
    check(bad_pulse == 0 && nlead == 8 && ntrail == 8, {tag, " R7 strobes"}, nlead + ntrail, 16);
    check(bad_map == 0, {tag, " R8 sample/shift map"}, bad_map, 0);
    cpha = ph;
  endtask

  task automatic t_reset();
    check(!sclk && !busy && !lead_en && !trail_en && !shift_en && !sample_en,
          "R1 reset state", {sclk, busy, lead_en, trail_en, shift_en, sample_en}, 0);
  endtask

  task automatic t_idle_level();
    @(negedge clk); cpol = 1'b1;
    @(negedge clk);
    check(sclk == 1'b1, "R2 idle follows cpol=1", sclk, 1);
    cpol = 1'b0;
    @(negedge clk);
    check(sclk == 1'b0, "R2 idle follows cpol=0", sclk, 0);
  endtask

  task automatic t_restart();
    @(negedge clk);
    rate_sel = 3'd2; cpha = 1'b0; cpol = 1'b0; load_stb = 1'b1;
    @(negedge clk); load_stb = 1'b0;
    repeat (40) @(negedge clk);
    check(busy == 1'b1, "R9 frame running before reload", busy, 1);
    xfer(1, 1'b1, 1'b1, 1'b0, "R9 reload");
  endtask

  task automatic t_disable();
    int moved;
    @(negedge clk);
    rate_sel = 3'd0; cpha = 1'b0; cpol = 1'b1; load_stb = 1'b1;
    @(negedge clk); load_stb = 1'b0;
    repeat (9) @(negedge clk);
    mst_en = 1'b0; cpol = 1'b0;
    @(negedge clk);
    check(!busy && sclk == 1'b0, "R11 abort on disable", {busy, sclk}, 0);
    load_stb = 1'b1;
    @(negedge clk); load_stb = 1'b0;
    moved = 0;
    repeat (30) begin
      if (busy || sclk || lead_en || trail_en) moved++;
      @(negedge clk);
    end
    check(moved == 0, "R11 strobe ignored while disabled", moved, 0);
    mst_en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    mst_en = 1'b1;
    t_idle_level();
    xfer(0, 1'b0, 1'b0, 1'b0, "R4 sel0 ph0 pol0");
    xfer(1, 1'b1, 1'b1, 1'b0, "R5 sel1 ph1 pol1");
    xfer(3, 1'b0, 1'b1, 1'b0, "R3 sel3 ph0 pol1");
    xfer(6, 1'b1, 1'b0, 1'b0, "R3 sel6 ph1 pol0");
    xfer(7, 1'b0, 1'b0, 1'b0, "R3 sel7 alias");
    xfer(2, 1'b0, 1'b1, 1'b1, "R10 changed inputs");
    xfer(0, 1'b1, 1'b0, 1'b1, "R10 changed inputs ph1");
    t_restart();
    t_disable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule